// File: doc/BRIEF.md
# Sine-Tone PWM Level Modulator

This block drives a single pulse-width-modulated pin whose low-pass filtered average sets the output amplitude of a synthesized RF source. A free-running 8-bit counter defines a PWM frame of 256 clock cycles. Each frame is about 31.25 kHz at an 8 MHz clock. The pin is high for the first `duty` cycles of each frame.

In continuous-wave mode the duty value follows the 8-bit level input directly, so the filtered voltage scales linearly with the setpoint. In tone mode the block adds a 1 kHz sinusoid to the setpoint, with a peak swing of 30 % of the setpoint. The sine is stored as a short sample table. A fractional phase accumulator advances through that table once per frame, so the tone averages exactly 1 kHz even though the frame rate is not a multiple of it. The accumulator runs in both modes.

Duty, mode and level are all sampled once per frame at the frame boundary. This prevents runt pulses when the inputs change.

Top module: `pwm_tone_level_mod`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is low and the tone phase is cleared. In the frame that starts right after reset, `pwm_out` stays low. The first tone-mode frame after that uses sine sample 0.
- R2: Each frame is 256 cycles long. Within a frame, `pwm_out` is high for exactly `duty` consecutive cycles starting at the frame's first cycle, then low for the rest of the frame.
- R3: With `mode_am` = 0 (continuous wave), `duty` equals `level` in every frame.
- R4: With `mode_am` = 1 (tone), `duty` = `level` + trunc(`level`·30·s / 12700). Here s is the sine sample round(127·sin(2πk/16)) for table index k, and trunc rounds toward zero.
- R5: The table index used for frame n+1 (n ≥ 0 counted from reset) is floor(n·4096000 / 8000000) mod 16. This gives 16 samples per 8000 clock cycles, which is exactly 1 kHz at 8 MHz.
- R6: The tone-mode duty saturates to the range 0 to 255 and never wraps.
- R7: `mode_am` and `level` are sampled only at the last cycle of a frame. A change in the middle of a frame leaves the current pulse untouched and takes effect in the next frame.
- R8: The phase advances in continuous-wave mode too. A switch to tone mode continues at the index given by R5 and does not restart at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_am | input | 1 | 0 = steady level, 1 = 1 kHz tone added |
| level | input | 8 | Carrier level setpoint |
| pwm_out | output | 1 | PWM output to the external RC filter |

## Verification
Several properties are checked on every cycle:
- the phase accumulator stays below the clock-rate modulus;
- the table index holds between frames and steps by at most one;
- the registered duty changes only at the frame start;
- rising edges of the pin occur only at the frame start, and falling edges only when the counter reaches the duty;
- continuous-wave duty equals the level, and tone-mode duty never drops below 70 % of the level.

The bench scenarios cover the behaviours those properties cannot show: the exact per-frame high time against the sine formula, saturation at full scale, phase continuity across a mode switch, a mid-frame change of the inputs, and the reset behaviour.

// File: rtl/pwm_tone_pkg.sv
package pwm_tone_pkg;

    typedef enum logic {
        MODE_STEADY = 1'b0,
        MODE_TONE   = 1'b1
    } tone_mode_e;

    // Rounded sine sample for table index k, scaled to +/- amp
    function automatic int sine_sample(int k, int points, int amp);
        real x;
        x = real'(amp) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(points));
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

endpackage

// File: rtl/tone_phase.sv
module tone_phase #(
    parameter int CLK_HZ  = 8_000_000,
    parameter int TONE_HZ = 1000,
    parameter int CNT_W   = 8,
    parameter int POINTS  = 16,
    localparam int IDX_W  = $clog2(POINTS),
    localparam int ACC_W  = $clog2(CLK_HZ) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    output logic [IDX_W-1:0] idx
);
    localparam longint FRAME = longint'(1) << CNT_W;
    localparam longint INC   = longint'(TONE_HZ) * FRAME * longint'(POINTS);
    localparam logic [ACC_W-1:0] INC_V = ACC_W'(INC);
    localparam logic [ACC_W-1:0] MOD_V = ACC_W'(CLK_HZ);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(POINTS - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [IDX_W-1:0] idx;
    } phase_t;

    phase_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, INC_V};
        if (frame_end) begin
            if (sum >= {1'b0, MOD_V}) begin
                st_d.acc = ACC_W'(sum - {1'b0, MOD_V});
                st_d.idx = (st_q.idx == LAST) ? '0 : st_q.idx + 1'b1;
            end else begin
                st_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;

    initial begin
        assert (INC < longint'(CLK_HZ))
            else $error("tone step per frame must be below one table step");
    end

    assert_acc_below_modulus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < MOD_V);

    assert_idx_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_q.idx));

    assert_idx_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (st_q.idx == $past(st_q.idx)) ||
                      (st_q.idx == (($past(st_q.idx) == LAST) ? '0 : $past(st_q.idx) + 1'b1)));

endmodule

// File: rtl/tone_mixer.sv
module tone_mixer
    import pwm_tone_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int POINTS    = 16,
    parameter int DEPTH_PCT = 30,
    parameter int AMP       = 127,
    localparam int IDX_W    = $clog2(POINTS),
    localparam int DMAX     = (1 << CNT_W) - 1
) (
    input  tone_mode_e       mode,
    input  logic [CNT_W-1:0] level,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] duty_next
);
    int sine_lut [POINTS];

    for (genvar g = 0; g < POINTS; g++) begin : g_lut
        localparam int SAMPLE = sine_sample(g, POINTS, AMP);
        assign sine_lut[g] = SAMPLE;
    end

    int offset;
    int total;

    always_comb begin
        offset = (int'(level) * DEPTH_PCT * sine_lut[idx]) / (100 * AMP);
        total  = int'(level) + offset;
        if (mode == MODE_STEADY) begin
            duty_next = level;
        end else if (total > DMAX) begin
            duty_next = CNT_W'(DMAX);
        end else if (total < 0) begin
            duty_next = '0;
        end else begin
            duty_next = CNT_W'(total);
        end
    end

endmodule

// File: rtl/pwm_slicer.sv
module pwm_slicer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_next,
    output logic             frame_end,
    output logic             pwm
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
        logic             pwm;
    } slice_t;

    slice_t st_d, st_q;

    assign frame_end = (st_q.cnt == '1);

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (frame_end) st_d.duty = duty_next;
        st_d.pwm = (st_d.cnt < st_d.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.pwm;

    assert_duty_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> $stable(st_q.duty));

    assert_rise_at_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pwm) |-> (st_q.cnt == '0));

    assert_fall_at_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pwm) |-> (st_q.cnt == st_q.duty));

endmodule

// File: rtl/pwm_tone_level_mod.sv
module pwm_tone_level_mod
    import pwm_tone_pkg::*;
#(
    parameter int CLK_HZ    = 8_000_000,
    parameter int TONE_HZ   = 1000,
    parameter int CNT_W     = 8,
    parameter int POINTS    = 16,
    parameter int DEPTH_PCT = 30,
    parameter int AMP       = 127,
    localparam int IDX_W    = $clog2(POINTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_am,
    input  logic [CNT_W-1:0] level,
    output logic             pwm_out
);
    logic             frame_end;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] duty_next;
    tone_mode_e       mode;

    assign mode = mode_am ? MODE_TONE : MODE_STEADY;

    tone_phase #(
        .CLK_HZ (CLK_HZ),
        .TONE_HZ(TONE_HZ),
        .CNT_W  (CNT_W),
        .POINTS (POINTS)
    ) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_end(frame_end),
        .idx      (idx)
    );

    tone_mixer #(
        .CNT_W    (CNT_W),
        .POINTS   (POINTS),
        .DEPTH_PCT(DEPTH_PCT),
        .AMP      (AMP)
    ) i_mixer (
        .mode     (mode),
        .level    (level),
        .idx      (idx),
        .duty_next(duty_next)
    );

    pwm_slicer #(
        .CNT_W(CNT_W)
    ) i_slicer (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_next(duty_next),
        .frame_end(frame_end),
        .pwm      (pwm_out)
    );

    assert_steady_follows_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_am |-> (duty_next == level));

    assert_tone_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_am |-> (int'(duty_next) >= (int'(level) * (100 - DEPTH_PCT)) / 100));

endmodule

// File: tb/test_pwm_tone_level_mod.sv
module test_pwm_tone_level_mod;

    localparam int FRAMES = 36;
    localparam int NV     = 9;

    typedef struct packed {
        logic       ma;
        logic [7:0] la;
        logic       mb;
        logic [7:0] lb;
        logic [7:0] sw;
    } vec_t;

    // mode/level before switch, mode/level after switch, switch frame (0 = none)
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0,   1'b0, 8'd0,   8'd0},
        '{1'b0, 8'd128, 1'b0, 8'd128, 8'd0},
        '{1'b0, 8'd255, 1'b0, 8'd255, 8'd0},
        '{1'b1, 8'd100, 1'b1, 8'd100, 8'd0},
        '{1'b1, 8'd255, 1'b1, 8'd255, 8'd0},
        '{1'b1, 8'd200, 1'b1, 8'd200, 8'd0},
        '{1'b0, 8'd50,  1'b1, 8'd50,  8'd10},
        '{1'b1, 8'd180, 1'b0, 8'd20,  8'd5},
        '{1'b1, 8'd1,   1'b1, 8'd1,   8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_am = 1'b0;
    logic [7:0] level = 8'd0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_tone_level_mod i_pwm_tone_level_mod (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_am(mode_am),
        .level  (level),
        .pwm_out(pwm_out)
    );

    function automatic int sine_ref(int k);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 16.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic int duty_ref(bit am, int lv, int k);
        int d;
        if (!am) return lv;
        d = lv + (lv * 30 * sine_ref(k)) / 12700;
        if (d > 255) d = 255;
        if (d < 0) d = 0;
        return d;
    endfunction

    function automatic string vec_tag(int v);
        case (v)
            4, 5:    return "R6";
            6:       return "R8";
            7:       return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, int v, int f, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s vector %0d frame %0d actual %0d expected %0d", req, v, f, act, exp);
        end
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            mode_am = VECS[v].ma;
            level   = VECS[v].la;
            @(negedge clk);
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            check("R1", v, -1, int'(pwm_out), 0);
            rst_n = 1'b1;
            for (int f = 0; f < FRAMES; f++) begin
                int  hi;
                int  rises_late;
                bit  prev;
                bit  use_b;
                int  k;
                int  exp_hi;
                hi = 0;
                rises_late = 0;
                prev = 1'b0;
                for (int c = 0; c < 256; c++) begin
                    if (VECS[v].sw != 0 && f == int'(VECS[v].sw) && c == 100) begin
                        mode_am = VECS[v].mb;
                        level   = VECS[v].lb;
                    end
                    if (pwm_out) hi++;
                    if (c > 0 && pwm_out && !prev) rises_late++;
                    prev = pwm_out;
                    @(negedge clk);
                end
                if (f == 0) begin
                    check("R1", v, f, hi, 0);
                end else begin
                    use_b  = (VECS[v].sw != 0) && (f > int'(VECS[v].sw));
                    k      = int'((longint'(f - 1) * 64'd4096000 / 64'd8000000) % 16);
                    exp_hi = use_b ? duty_ref(VECS[v].mb, int'(VECS[v].lb), k)
                                   : duty_ref(VECS[v].ma, int'(VECS[v].la), k);
                    if ((use_b ? VECS[v].mb : VECS[v].ma) == 1'b0)
                        check({"R3/", vec_tag(v)}, v, f, hi, exp_hi);
                    else
                        check({"R4/", vec_tag(v)}, v, f, hi, exp_hi);
                end
                check("R2", v, f, rises_late, 0);
            end
        end

        // Directed: asynchronous reset while the pin is high forces it low (R1)
        mode_am = 1'b0;
        level   = 8'd200;
        repeat (600) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        #1 rst_n = 1'b0;
        #1 check("R1", -1, -1, int'(pwm_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog actual timeout expected completion");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule